// File: doc/BRIEF.md
# Warp Issue Scheduler with Split Scoreboards

This block picks instructions for one scheduler slice of a throughput processor. Up to `NUM_WARPS` warps live in the slice at once, and each shows the block one pending instruction. Every instruction has an operation class, two source registers and a destination register. On each clock the scheduler sends out no more than one instruction, taken from a warp whose registers are all free. A warp that is waiting on memory never holds up the others. Moving from one warp to another costs no cycles, because no per-warp state is saved or restored.

The block tracks register hazards for each warp in three separate structures. A long scoreboard holds global loads, which take hundreds of cycles. A short scoreboard holds shared-memory loads, which take tens of cycles. A fixed-depth pipeline covers arithmetic results. The surrounding memory system reports load completion on two writeback ports, one for each scoreboard. Arithmetic results clear by themselves once `ALU_LAT` cycles have passed. When no warp can issue in a cycle, the block flags that cycle as idle and counts it as an empty issue slot.

Top module: `warp_issue_sched`

## Requirements
- R1: Each clock edge issues at most one instruction, from a single warp. The block registers the issue outputs (`issue_valid`, `issue_warp`, `issue_op`, `issue_dst`), so they show the decision made at that edge. Operation class codes are 0 = arithmetic, 1 = shared load, 2 = global load, 3 = store.
- R2: A warp can issue only when its slot is valid and none of these registers is pending: source 0, source 1, and the destination. A store does not check the destination.
- R3: The scheduler searches eligible warps in round-robin order. The search starts at the warp after the one issued most recently and wraps around. After reset the search starts at warp 0.
- R4: A warp that issues at one edge cannot issue at the next edge, because that cycle is used to reload its slot. A different warp can issue at that next edge with no empty slot in between.
- R5: Issuing a global load marks its destination as pending in that warp's long scoreboard. Only a long writeback carrying the same warp and register clears it.
- R6: Issuing a shared load marks its destination as pending in the short scoreboard. Only a short writeback clears it. A long writeback does not clear a short entry.
- R7: An arithmetic instruction keeps its destination pending so that a dependent instruction can issue no earlier than `ALU_LAT` edges after it.
- R8: A store marks nothing as pending. An instruction from the same warp that reads the store's destination field can issue at the next edge where that warp is not held.
- R9: If a writeback arrives in the same cycle as the eligibility check, the writeback applies first. A warp waiting only on that register can issue at that very edge.
- R10: When no warp issues at an edge, `idle` goes high for that cycle and `empty_slots` increases by one. At any other edge, `empty_slots` keeps its value.
- R11: Reset clears `issue_valid`, `idle`, `empty_slots` and all scoreboards.
- R12: A warp stalled on a long load does not stop other eligible warps from issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | NUM_WARPS | One bit per warp: the slot holds an instruction |
| instr_op | input | 2*NUM_WARPS | Operation class, one 2-bit field per warp |
| instr_src0 | input | RW*NUM_WARPS | First source register, one field per warp |
| instr_src1 | input | RW*NUM_WARPS | Second source register, one field per warp |
| instr_dst | input | RW*NUM_WARPS | Destination register, one field per warp |
| lwb_valid | input | 1 | Global-load writeback strobe |
| lwb_warp | input | WW | Warp of the global-load writeback |
| lwb_reg | input | RW | Register of the global-load writeback |
| swb_valid | input | 1 | Shared-load writeback strobe |
| swb_warp | input | WW | Warp of the shared-load writeback |
| swb_reg | input | RW | Register of the shared-load writeback |
| issue_valid | output | 1 | An instruction was issued at the last edge |
| issue_warp | output | WW | Warp that issued |
| issue_op | output | 2 | Class of the issued instruction |
| issue_dst | output | RW | Destination field of the issued instruction |
| idle | output | 1 | No warp issued at the last edge |
| empty_slots | output | CNT_W | Running count of idle edges |

## Verification
The assertions rely on the environment keeping a few rules. Writebacks only name a register that the matching scoreboard has outstanding for that warp. Each port carries at most one writeback per cycle. A warp's slot is reloaded during the cycle in which that warp is held. The bench follows these rules by construction. It sends each writeback as a single-cycle pulse, and only for loads it has already seen issue, apart from deliberate pulses to the wrong port or the wrong warp. Those deliberate pulses target registers left pending on purpose, so no assertion treats them as hazards. The bench changes descriptors only at the falling edge after it sees the matching issue.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_SHLD = 2'd1,
    OP_GLD  = 2'd2,
    OP_ST   = 2'd3
  } op_class_e;
endpackage

// File: rtl/wis_alu_pipe.sv
// Fixed-latency tracker for arithmetic results: an entry blocks its register
// until it reaches the last stage, where it is treated as written back.
module wis_alu_pipe #(
  parameter int NUM_WARPS = 16,
  parameter int NUM_REGS  = 32,
  parameter int ALU_LAT   = 4,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                push,
  input  logic [WW-1:0]                       push_warp,
  input  logic [RW-1:0]                       push_reg,
  output logic [NUM_WARPS-1:0][NUM_REGS-1:0]  busy_mask
);
  logic [ALU_LAT-1:0] vld_q;
  logic [WW-1:0]      warp_q [ALU_LAT];
  logic [RW-1:0]      reg_q  [ALU_LAT];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[ALU_LAT-2:0], push};
  end

  always_ff @(posedge clk) begin
    warp_q[0] <= push_warp;
    reg_q[0]  <= push_reg;
    for (int s = 1; s < ALU_LAT; s++) begin
      warp_q[s] <= warp_q[s-1];
      reg_q[s]  <= reg_q[s-1];
    end
  end

  always_comb begin
    busy_mask = '0;
    for (int s = 0; s < ALU_LAT - 1; s++) begin
      if (vld_q[s]) busy_mask[warp_q[s]][reg_q[s]] = 1'b1;
    end
  end
endmodule

// File: rtl/wis_warp_scoreboard.sv
// Per-warp long and short pending-register sets with writeback bypass.
module wis_warp_scoreboard
  import wis_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_long,
  input  logic                set_short,
  input  logic [RW-1:0]       set_reg,
  input  logic                clr_long,
  input  logic [RW-1:0]       clr_long_reg,
  input  logic                clr_short,
  input  logic [RW-1:0]       clr_short_reg,
  input  logic [NUM_REGS-1:0] alu_busy,
  input  logic [1:0]          op,
  input  logic [RW-1:0]       src0,
  input  logic [RW-1:0]       src1,
  input  logic [RW-1:0]       dst,
  output logic                ready
);
  logic [NUM_REGS-1:0] long_q, short_q;
  logic [NUM_REGS-1:0] long_eff, short_eff, long_nxt, short_nxt, blocked;

  always_comb begin
    long_eff  = long_q;
    short_eff = short_q;
    if (clr_long)  long_eff[clr_long_reg]   = 1'b0;
    if (clr_short) short_eff[clr_short_reg] = 1'b0;
    long_nxt  = long_eff;
    short_nxt = short_eff;
    if (set_long)  long_nxt[set_reg]  = 1'b1;
    if (set_short) short_nxt[set_reg] = 1'b1;
    blocked = long_eff | short_eff | alu_busy;
    ready   = !blocked[src0] && !blocked[src1] &&
              ((op == OP_ST) || !blocked[dst]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      long_q  <= '0;
      short_q <= '0;
    end else begin
      long_q  <= long_nxt;
      short_q <= short_nxt;
    end
  end
endmodule

// File: rtl/wis_rr_pick.sv
// Round-robin selection starting one past the last issued warp.
module wis_rr_pick #(
  parameter int NUM_WARPS = 16,
  localparam int WW = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] eligible,
  input  logic [WW-1:0]        last,
  output logic                 any,
  output logic [WW-1:0]        pick
);
  logic [WW-1:0] idx;

  always_comb begin
    any  = 1'b0;
    pick = last;
    idx  = last;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      idx = last + WW'(i);
      if (!any && eligible[idx]) begin
        any  = 1'b1;
        pick = idx;
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int NUM_REGS  = 32,
  parameter int ALU_LAT   = 4,
  parameter int CNT_W     = 32,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_WARPS-1:0]    instr_valid,
  input  logic [2*NUM_WARPS-1:0]  instr_op,
  input  logic [RW*NUM_WARPS-1:0] instr_src0,
  input  logic [RW*NUM_WARPS-1:0] instr_src1,
  input  logic [RW*NUM_WARPS-1:0] instr_dst,
  input  logic                    lwb_valid,
  input  logic [WW-1:0]           lwb_warp,
  input  logic [RW-1:0]           lwb_reg,
  input  logic                    swb_valid,
  input  logic [WW-1:0]           swb_warp,
  input  logic [RW-1:0]           swb_reg,
  output logic                    issue_valid,
  output logic [WW-1:0]           issue_warp,
  output logic [1:0]              issue_op,
  output logic [RW-1:0]           issue_dst,
  output logic                    idle,
  output logic [CNT_W-1:0]        empty_slots
);
  logic [NUM_WARPS-1:0][1:0]          op_arr;
  logic [NUM_WARPS-1:0][RW-1:0]       src0_arr, src1_arr, dst_arr;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] alu_busy;
  logic [NUM_WARPS-1:0]               ready, eligible, hold_q;
  logic [WW-1:0]                      last_q, grant_w;
  logic                               grant_any;
  logic [1:0]                         grant_op;
  logic [RW-1:0]                      grant_dst;

  assign grant_op  = op_arr[grant_w];
  assign grant_dst = dst_arr[grant_w];
  assign eligible  = instr_valid & ~hold_q & ready;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic own_grant;
    assign op_arr[w]   = instr_op[2*w +: 2];
    assign src0_arr[w] = instr_src0[RW*w +: RW];
    assign src1_arr[w] = instr_src1[RW*w +: RW];
    assign dst_arr[w]  = instr_dst[RW*w +: RW];
    assign own_grant   = grant_any && (grant_w == WW'(w));

    wis_warp_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
      .clk           (clk),
      .rst           (rst),
      .set_long      (own_grant && (grant_op == OP_GLD)),
      .set_short     (own_grant && (grant_op == OP_SHLD)),
      .set_reg       (grant_dst),
      .clr_long      (lwb_valid && (lwb_warp == WW'(w))),
      .clr_long_reg  (lwb_reg),
      .clr_short     (swb_valid && (swb_warp == WW'(w))),
      .clr_short_reg (swb_reg),
      .alu_busy      (alu_busy[w]),
      .op            (op_arr[w]),
      .src0          (src0_arr[w]),
      .src1          (src1_arr[w]),
      .dst           (dst_arr[w]),
      .ready         (ready[w])
    );
  end

  wis_alu_pipe #(
    .NUM_WARPS (NUM_WARPS),
    .NUM_REGS  (NUM_REGS),
    .ALU_LAT   (ALU_LAT)
  ) u_alu (
    .clk       (clk),
    .rst       (rst),
    .push      (grant_any && (grant_op == OP_ALU)),
    .push_warp (grant_w),
    .push_reg  (grant_dst),
    .busy_mask (alu_busy)
  );

  wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .eligible (eligible),
    .last     (last_q),
    .any      (grant_any),
    .pick     (grant_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      last_q      <= WW'(NUM_WARPS - 1);
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_op    <= '0;
      issue_dst   <= '0;
      idle        <= 1'b0;
      empty_slots <= '0;
    end else begin
      hold_q <= '0;
      if (grant_any) begin
        hold_q[grant_w] <= 1'b1;
        last_q          <= grant_w;
      end
      issue_valid <= grant_any;
      issue_warp  <= grant_w;
      issue_op    <= grant_op;
      issue_dst   <= grant_dst;
      idle        <= !grant_any;
      empty_slots <= empty_slots + CNT_W'(!grant_any);
    end
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W     = 32,
  localparam int WW = $clog2(NUM_WARPS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_WARPS-1:0] instr_valid,
  input logic                 issue_valid,
  input logic [WW-1:0]        issue_warp,
  input logic                 idle,
  input logic [CNT_W-1:0]     empty_slots
);
  logic [NUM_WARPS-1:0] vld_q;
  always_ff @(posedge clk) vld_q <= instr_valid;

  assert_hold_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid)) |-> (issue_warp != $past(issue_warp)));

  assert_idle_count_R10: assert property (@(posedge clk) disable iff (rst)
    idle |-> (empty_slots == $past(empty_slots) + CNT_W'(1)));

  assert_busy_count_R10: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (empty_slots == $past(empty_slots)));

  assert_valid_slot_R2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> vld_q[issue_warp]);

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!issue_valid && !idle && (empty_slots == '0)));
endmodule

bind warp_issue_sched wis_checker #(
  .NUM_WARPS (NUM_WARPS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .issue_valid (issue_valid),
  .issue_warp  (issue_warp),
  .idle        (idle),
  .empty_slots (empty_slots)
);

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW = 4;
  localparam int NR = 8;
  localparam int AL = 4;
  localparam int CW = 16;
  localparam int WW = 2;
  localparam int RW = 3;
  localparam logic [1:0] ALU = 2'd0, SHLD = 2'd1, GLD = 2'd2, ST = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NW-1:0]    vld;
  logic [1:0]       op_a [NW];
  logic [RW-1:0]    s0_a [NW], s1_a [NW], d_a [NW];
  logic [2*NW-1:0]  instr_op;
  logic [RW*NW-1:0] instr_src0, instr_src1, instr_dst;
  logic             lwb_valid = 1'b0, swb_valid = 1'b0;
  logic [WW-1:0]    lwb_warp = '0, swb_warp = '0;
  logic [RW-1:0]    lwb_reg = '0, swb_reg = '0;
  logic             issue_valid, idle;
  logic [WW-1:0]    issue_warp;
  logic [1:0]       issue_op;
  logic [RW-1:0]    issue_dst;
  logic [CW-1:0]    empty_slots;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      instr_op[2*w +: 2]    = op_a[w];
      instr_src0[RW*w +: RW] = s0_a[w];
      instr_src1[RW*w +: RW] = s1_a[w];
      instr_dst[RW*w +: RW]  = d_a[w];
    end
  end

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .ALU_LAT(AL), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .instr_valid(vld), .instr_op(instr_op),
    .instr_src0(instr_src0), .instr_src1(instr_src1), .instr_dst(instr_dst),
    .lwb_valid(lwb_valid), .lwb_warp(lwb_warp), .lwb_reg(lwb_reg),
    .swb_valid(swb_valid), .swb_warp(swb_warp), .swb_reg(swb_reg),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_op(issue_op),
    .issue_dst(issue_dst), .idle(idle), .empty_slots(empty_slots));

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_w(int w, bit v, logic [1:0] o, int a, int b, int c);
    vld[w] = v; op_a[w] = o; s0_a[w] = RW'(a); s1_a[w] = RW'(b); d_a[w] = RW'(c);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int w = 0; w < NW; w++) set_w(w, 0, ALU, 0, 0, 0);
    lwb_valid = 1'b0; swb_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 issue_valid in reset", int'(issue_valid), 0);
    check("R11 idle in reset", int'(idle), 0);
    check("R11 empty_slots in reset", int'(empty_slots), 0);
    rst = 1'b0;
  endtask

  // expects an issue from warp w with class o at the edge just passed
  task automatic exp_issue(string req, int w, int o);
    check({req, " issue_valid"}, int'(issue_valid), 1);
    check({req, " issue_warp"}, int'(issue_warp), w);
    check({req, " issue_op"}, int'(issue_op), o);
  endtask

  task automatic exp_idle(string req);
    check({req, " idle"}, int'(idle), 1);
    check({req, " issue_valid"}, int'(issue_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w1_cnt;
    vld = '0;
    // Sweep of every nonempty set of always-ready store warps: R3, R4, R10, R1
    for (int m = 1; m < (1 << NW); m++) begin
      int last, hold, cnt;
      do_reset();
      for (int w = 0; w < NW; w++) set_w(w, m[w], ST, 0, 1, 0);
      last = NW - 1; hold = -1; cnt = 0;
      for (int k = 0; k < 8; k++) begin
        int pick;
        pick = -1;
        for (int i = 1; i <= NW; i++) begin
          int idx;
          idx = (last + i) % NW;
          if (pick < 0 && m[idx] && idx != hold) pick = idx;
        end
        step();
        if (pick >= 0) begin
          check("R3 R4 sweep issue_valid", int'(issue_valid), 1);
          check("R3 sweep round-robin warp", int'(issue_warp), pick);
          last = pick; hold = pick;
        end else begin
          check("R4 sweep held-only idle", int'(idle), 1);
          hold = -1; cnt++;
        end
        check("R10 sweep empty_slots", int'(empty_slots), cnt);
      end
    end

    // Long load stall, other warps proceed, wrong-port/warp writebacks: R5, R12, R6, R9
    do_reset();
    set_w(0, 1, GLD, 0, 1, 3);
    set_w(1, 1, ST, 0, 1, 0);
    step();
    exp_issue("R5 global load", 0, GLD);
    check("R1 issue_dst", int'(issue_dst), 3);
    set_w(0, 1, ALU, 3, 1, 5);
    w1_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      check("R5 dependent warp blocked", int'(issue_valid && issue_warp == 0), 0);
      if (issue_valid && issue_warp == 1) w1_cnt++;
    end
    check("R12 other warp keeps issuing", w1_cnt, 5);
    swb_valid = 1'b1; swb_warp = 0; swb_reg = 3;
    step();
    swb_valid = 1'b0;
    check("R6 short writeback leaves long entry", int'(issue_valid && issue_warp == 0), 0);
    lwb_valid = 1'b1; lwb_warp = 1; lwb_reg = 3;
    step();
    lwb_valid = 1'b0;
    check("R5 other-warp writeback leaves entry", int'(issue_valid && issue_warp == 0), 0);
    vld[1] = 1'b0;
    lwb_valid = 1'b1; lwb_warp = 0; lwb_reg = 3;
    step();
    lwb_valid = 1'b0;
    exp_issue("R9 same-cycle long writeback", 0, ALU);
    vld[0] = 1'b0;

    // Short scoreboard: R6, R9
    do_reset();
    set_w(0, 1, SHLD, 0, 1, 2);
    step();
    exp_issue("R6 shared load", 0, SHLD);
    set_w(0, 1, ALU, 4, 2, 6);
    step();
    exp_idle("R4 hold after issue");
    lwb_valid = 1'b1; lwb_warp = 0; lwb_reg = 2;
    step();
    lwb_valid = 1'b0;
    exp_idle("R6 long writeback ignored by short entry");
    step();
    exp_idle("R6 still pending");
    swb_valid = 1'b1; swb_warp = 0; swb_reg = 2;
    step();
    swb_valid = 1'b0;
    exp_issue("R6 R9 short writeback releases", 0, ALU);
    vld[0] = 1'b0;

    // Arithmetic latency and destination hazard: R7, R2, R10
    do_reset();
    set_w(0, 1, ALU, 0, 1, 4);
    step();
    exp_issue("R7 first alu", 0, ALU);
    set_w(0, 1, ALU, 4, 0, 6);
    step(); exp_idle("R7 edge+1");
    step(); exp_idle("R7 edge+2");
    step(); exp_idle("R7 edge+3");
    step();
    exp_issue("R7 dependent at ALU_LAT", 0, ALU);
    set_w(0, 1, ALU, 0, 1, 6);
    step(); exp_idle("R2 dst hazard edge+1");
    step(); exp_idle("R2 dst hazard edge+2");
    step(); exp_idle("R2 dst hazard edge+3");
    step();
    exp_issue("R2 dst hazard released", 0, ALU);
    check("R10 idle count", int'(empty_slots), 6);
    vld[0] = 1'b0;

    // Store behaviour: R8, R2, R5
    do_reset();
    set_w(0, 1, GLD, 0, 1, 7);
    step();
    exp_issue("R5 global load r7", 0, GLD);
    set_w(0, 1, ST, 0, 1, 7);
    step(); exp_idle("R4 hold");
    step();
    exp_issue("R8 store ignores pending dst", 0, ST);
    set_w(0, 1, ST, 0, 1, 5);
    step(); exp_idle("R4 hold");
    step();
    exp_issue("R8 store r5", 0, ST);
    set_w(0, 1, ALU, 5, 5, 6);
    step(); exp_idle("R4 hold");
    step();
    exp_issue("R8 store set nothing", 0, ALU);
    set_w(0, 1, ALU, 0, 1, 7);
    step(); exp_idle("R4 hold");
    step(); exp_idle("R2 dst on long entry blocks");
    lwb_valid = 1'b1; lwb_warp = 0; lwb_reg = 7;
    step();
    lwb_valid = 1'b0;
    exp_issue("R5 long writeback releases dst", 0, ALU);
    vld[0] = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule